// File: doc/BRIEF.md
# Triggered Circular Sample Buffer Controller

This block manages a ring of sample cells that acts as a level-1 trigger buffer. Every cycle with a valid sample, the sample goes into the next free cell of the ring. A level-1 accept arrives a fixed number of cells after the event it selects. The block then steps back that many cells from the current write position and freezes a short run of consecutive cells. The start address of that run is queued for readout.

A separate read port drains the queued events in trigger order. It emits one cell per requested cycle and marks the first sample of each event. Sampling never pauses while readout runs, so the buffer has no dead time. Frozen cells are skipped by the writer until they have been read. Cells that no trigger selected are simply overwritten on the next lap.

The ring depth, the latency in cells, the group size (3 or 4), the event queue depth and the data width are all parameters.

Top module: `l1_sample_ring`

## Requirements
- R1: Every cycle with `sampleValid` high and a free cell available, `sampleData` is stored in the first non-frozen cell at or after the write position. The write position then moves to the cell after the one just written.
- R2: An accepted `l1Accept` freezes GROUP consecutive cells. The first of them lies LAT cells before the write position held at the start of that cycle, so a sample taken in the same cycle does not shift it. That first cell is the first address read out for the event.
- R3: When at least one event is pending and `rdReady` is high, exactly one cell of the oldest event appears on the next cycle with `rdValid` high. Cells of an event come out in ascending ring order. `rdSoe` is 1 on the first cell of each event and 0 on the others. With no event pending, `rdValid` stays 0.
- R4: A frozen cell is never overwritten. The writer skips over frozen cells to the next free cell in ring order, so data read out equals the sample stored at that cell.
- R5: Each cell is released in the cycle it is read. Cells no trigger froze are overwritten on later laps.
- R6: Sample writing continues in the same cycles as readout, with no stall.
- R7: Up to EVQ events can be pending, and their count is shown on `eventsPending`. An `l1Accept` that arrives while EVQ events are pending is rejected and counted.
- R8: An `l1Accept` whose cell group would include an already frozen cell is rejected. `trigRejectCnt` counts all rejected accepts and saturates at its maximum.
- R9: A valid sample that finds every cell frozen is dropped. `bufOverflow` then goes to 1 and stays there until reset.
- R10: Reset sets the write position to cell 0, clears all freeze marks and the event queue, and drives `rdValid`, `bufOverflow`, `eventsPending` and `trigRejectCnt` to 0.
- R11: All address arithmetic (step-back, group run, write skip) wraps modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | Sample present this cycle |
| sampleData | input | DW | Digitized sample |
| l1Accept | input | 1 | Level-1 accept pulse |
| rdReady | input | 1 | Request one readout cell this cycle |
| rdValid | output | 1 | Readout cell present |
| rdSoe | output | 1 | First cell of an event |
| rdAddr | output | $clog2(DEPTH) | Ring address of the readout cell |
| rdData | output | DW | Sample held in that cell |
| bufOverflow | output | 1 | Sticky: a sample was dropped |
| eventsPending | output | $clog2(EVQ+1) | Events waiting for readout |
| trigRejectCnt | output | CNT_W | Saturating count of rejected accepts |

## Verification
The hardest state to reach is a ring where every cell is frozen, since that needs EVQ event groups that tile the ring exactly without overlapping. The bench uses a small ring whose depth equals the queue depth times the group size, with a latency equal to the group size. Accepts are spaced one group of samples apart, so each group freezes exactly the samples just written. After the last group wraps onto the final cells, the next sample must overflow and a further accept must be rejected for a full queue. A table-driven phase runs reads alongside writes, back-to-back overlapping accepts and a step-back that wraps past cell 0, checked against a model of the requirements.

// File: rtl/ring_buf_pkg.sv
`timescale 1ns/1ps
package ring_buf_pkg;
  // Strobes passed from the controller to the datapath each cycle.
  typedef struct packed {
    logic wrEn;     // store sampleData at wrAddr
    logic rdEn;     // capture cell rdAddr into the output stage
    logic rdFirst;  // the captured cell opens an event
  } ringStrobe_t;
endpackage

// File: rtl/evq_fifo.sv
`timescale 1ns/1ps
module evq_fifo #(
  parameter int WIDTH   = 8,
  parameter int ENTRIES = 16,
  localparam int PW = $clog2(ENTRIES),
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] slots [ENTRIES];
  logic [PW-1:0]    headPtr, tailPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[tailPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (push) tailPtr <= bump(tailPtr);
      if (pop)  headPtr <= bump(headPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign headData = slots[headPtr];
  assign full     = (count == CW'(ENTRIES));
  assign empty    = (count == '0);

  // R7
  evq_no_overpush_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R3
  evq_no_underpop_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/ring_ctrl.sv
`timescale 1ns/1ps
module ring_ctrl
  import ring_buf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LAT   = 160,
  parameter int GROUP = 4,
  parameter int EVQ   = 16,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int QW = $clog2(EVQ + 1),
  localparam int IW = $clog2(GROUP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic             l1Accept,
  input  logic             rdReady,
  output ringStrobe_t      stb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             overflow,
  output logic [QW-1:0]    eventsPending,
  output logic [CNT_W-1:0] rejectCnt
);
  // Stepping back LAT cells is done as stepping forward BACK cells.
  localparam int BACK = DEPTH - (LAT % DEPTH);

  function automatic logic [AW-1:0] ringAdd(input logic [AW-1:0] a,
                                            input int unsigned b);
    int unsigned s;
    s = (32'(a) + b) % DEPTH;
    return AW'(s);
  endfunction

  logic [DEPTH-1:0] frozen, grpMask, blocked, clrMask, setMask;
  logic [AW-1:0]    wrPtr, trigStart, freeAddr, headAddr;
  logic [IW-1:0]    rdIdx;
  logic             freeFound, grpConflict, trigAccept;
  logic             qFull, qEmpty, rdLast, popEv;

  // Trigger side: locate the group and decide acceptance.
  assign trigStart = ringAdd(wrPtr, BACK);

  always_comb begin
    grpMask = '0;
    for (int g = 0; g < GROUP; g++) grpMask[ringAdd(trigStart, 32'(g))] = 1'b1;
  end

  assign grpConflict = |(frozen & grpMask);
  assign trigAccept  = l1Accept && !qFull && !grpConflict;
  assign setMask     = trigAccept ? grpMask : '0;

  // Write side: first cell, in ring order from wrPtr, that is neither
  // frozen nor being frozen this cycle.
  assign blocked = frozen | setMask;

  always_comb begin
    freeFound = 1'b0;
    freeAddr  = wrPtr;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!blocked[ringAdd(wrPtr, 32'(i))]) begin
        freeFound = 1'b1;
        freeAddr  = ringAdd(wrPtr, 32'(i));
      end
    end
  end

  // Read side: walk the oldest group one cell per granted cycle.
  assign rdAddr = ringAdd(headAddr, 32'(rdIdx));
  assign rdLast = (rdIdx == IW'(GROUP - 1));

  always_comb begin
    stb.wrEn    = sampleValid && freeFound;
    stb.rdEn    = rdReady && !qEmpty;
    stb.rdFirst = (rdIdx == '0);
  end

  assign wrAddr = freeAddr;
  assign popEv  = stb.rdEn && rdLast;

  always_comb begin
    clrMask = '0;
    if (stb.rdEn) clrMask[rdAddr] = 1'b1;
  end

  evq_fifo #(.WIDTH(AW), .ENTRIES(EVQ)) evq (
    .clk      (clk),
    .rst      (rst),
    .push     (trigAccept),
    .pushData (trigStart),
    .pop      (popEv),
    .headData (headAddr),
    .full     (qFull),
    .empty    (qEmpty),
    .count    (eventsPending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      frozen    <= '0;
      rdIdx     <= '0;
      overflow  <= 1'b0;
      rejectCnt <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= ringAdd(freeAddr, 1);
      frozen <= (frozen & ~clrMask) | setMask;
      if (stb.rdEn) rdIdx <= rdLast ? '0 : rdIdx + 1'b1;
      if (sampleValid && !freeFound) overflow <= 1'b1;
      if (l1Accept && !trigAccept && (rejectCnt != '1))
        rejectCnt <= rejectCnt + 1'b1;
    end
  end

  // R4
  wr_free_chk: assert property (@(posedge clk) disable iff (rst)
    stb.wrEn |-> !frozen[wrAddr]);
  // R3
  rd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    stb.rdEn |-> frozen[rdAddr]);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R8
  rej_mono_chk: assert property (@(posedge clk) disable iff (rst)
    rejectCnt >= $past(rejectCnt));
  // R7
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    eventsPending <= QW'(EVQ));
endmodule

// File: rtl/ring_dp.sv
`timescale 1ns/1ps
module ring_dp
  import ring_buf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  ringStrobe_t   stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] sampleData,
  output logic          rdValid,
  output logic          rdSoe,
  output logic [AW-1:0] rdAddrQ,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrEn) cells[wrAddr] <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdSoe   <= 1'b0;
    end else begin
      rdValid <= stb.rdEn;
      rdSoe   <= stb.rdEn && stb.rdFirst;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.rdEn) begin
      rdData  <= cells[rdAddr];
      rdAddrQ <= rdAddr;
    end
  end

  // R3
  soe_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rdSoe |-> rdValid);
  // R4
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && stb.rdEn) |-> (wrAddr != rdAddr));
endmodule

// File: rtl/l1_sample_ring.sv
`timescale 1ns/1ps
module l1_sample_ring
  import ring_buf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LAT   = 160,
  parameter int GROUP = 4,
  parameter int EVQ   = 16,
  parameter int DW    = 12,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int QW = $clog2(EVQ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic [DW-1:0]    sampleData,
  input  logic             l1Accept,
  input  logic             rdReady,
  output logic             rdValid,
  output logic             rdSoe,
  output logic [AW-1:0]    rdAddr,
  output logic [DW-1:0]    rdData,
  output logic             bufOverflow,
  output logic [QW-1:0]    eventsPending,
  output logic [CNT_W-1:0] trigRejectCnt
);
  ringStrobe_t   stb;
  logic [AW-1:0] wrAddr, rdAddrC;

  ring_ctrl #(
    .DEPTH(DEPTH), .LAT(LAT), .GROUP(GROUP), .EVQ(EVQ), .CNT_W(CNT_W)
  ) ctrl (
    .clk           (clk),
    .rst           (rst),
    .sampleValid   (sampleValid),
    .l1Accept      (l1Accept),
    .rdReady       (rdReady),
    .stb           (stb),
    .wrAddr        (wrAddr),
    .rdAddr        (rdAddrC),
    .overflow      (bufOverflow),
    .eventsPending (eventsPending),
    .rejectCnt     (trigRejectCnt)
  );

  ring_dp #(.DEPTH(DEPTH), .DW(DW)) dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddrC),
    .sampleData (sampleData),
    .rdValid    (rdValid),
    .rdSoe      (rdSoe),
    .rdAddrQ    (rdAddr),
    .rdData     (rdData)
  );
endmodule

// File: tb/l1_sample_ring_test.sv
`timescale 1ns/1ps
module l1_sample_ring_test;
  localparam int D  = 16;
  localparam int L  = 4;
  localparam int G  = 4;
  localparam int Q  = 4;
  localparam int DWT = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleData = '0;
  logic       l1Accept = 1'b0;
  logic       rdReady = 1'b0;
  logic       rdValid, rdSoe, bufOverflow;
  logic [3:0] rdAddr;
  logic [7:0] rdData;
  logic [2:0] eventsPending;
  logic [7:0] trigRejectCnt;

  always #5 clk = ~clk;

  l1_sample_ring #(.DEPTH(D), .LAT(L), .GROUP(G), .EVQ(Q), .DW(DWT), .CNT_W(8)) uut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleData(sampleData),
    .l1Accept(l1Accept), .rdReady(rdReady), .rdValid(rdValid), .rdSoe(rdSoe),
    .rdAddr(rdAddr), .rdData(rdData), .bufOverflow(bufOverflow),
    .eventsPending(eventsPending), .trigRejectCnt(trigRejectCnt)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  // Requirement model state
  int   mWr, mHead, mCnt, mIdx, mRej;
  bit   mOvf;
  bit   mFrozen [D];
  logic [7:0] mMem [D];
  int   mQ [Q];
  int   dataCtr = 1;
  // Expected read output of the latest step
  bit   eV, eS;
  int   eA, eD;

  task automatic chk(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mWr = 0; mHead = 0; mCnt = 0; mIdx = 0; mRej = 0; mOvf = 0;
    for (int i = 0; i < D; i++) mFrozen[i] = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sampleValid = 0; l1Accept = 0; rdReady = 0;
    repeat (2) @(posedge clk);
    #1;
    // R10: state held under reset
    chk("R10 rdValid", rdValid, 0);
    chk("R10 bufOverflow", bufOverflow, 0);
    chk("R10 eventsPending", eventsPending, 0);
    chk("R10 trigRejectCnt", trigRejectCnt, 0);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  // One clock: drive, predict from the requirements, then compare.
  task automatic step(input bit v, input bit t, input bit r);
    int start, c;
    bit conflict, acc, found;
    @(negedge clk);
    sampleValid = v; l1Accept = t; rdReady = r;
    sampleData = 8'(dataCtr);
    // R2 / R11: group start LAT cells behind the write position
    start = (mWr - L + D) % D;
    conflict = 0;
    for (int g = 0; g < G; g++) if (mFrozen[(start + g) % D]) conflict = 1;
    acc = t && (mCnt < Q) && !conflict;
    if (t && !acc && mRej < 255) mRej++;
    // R3: read of the oldest pending event
    eV = r && (mCnt > 0);
    if (eV) begin
      eA = (mQ[mHead] + mIdx) % D;
      eD = int'(mMem[eA]);
      eS = (mIdx == 0);
    end
    // R1 / R4: write into the first cell that is not blocked
    if (v) begin
      found = 0;
      c = mWr;
      for (int i = 0; i < D; i++) begin
        int k;
        k = (mWr + i) % D;
        if (!found && !mFrozen[k] && !(acc && ((k - start + D) % D) < G)) begin
          found = 1; c = k;
        end
      end
      if (found) begin
        mMem[c] = 8'(dataCtr);
        mWr = (c + 1) % D;
      end else mOvf = 1;
    end
    if (acc) begin
      for (int g = 0; g < G; g++) mFrozen[(start + g) % D] = 1;
      mQ[(mHead + mCnt) % Q] = start;
      mCnt++;
    end
    if (eV) begin
      mFrozen[eA] = 0;
      if (mIdx == G - 1) begin
        mIdx = 0; mHead = (mHead + 1) % Q; mCnt--;
      end else mIdx++;
    end
    @(posedge clk);
    #1;
    chk("R3 R6 rdValid", rdValid, eV);
    if (eV) begin
      chk("R3 rdSoe", rdSoe, eS);
      chk("R2 R11 rdAddr", rdAddr, eA);
      chk("R1 R4 R5 rdData", rdData, eD);
    end
    chk("R9 bufOverflow", bufOverflow, mOvf);
    chk("R7 eventsPending", eventsPending, mCnt);
    chk("R8 trigRejectCnt", trigRejectCnt, mRej);
    dataCtr++;
  endtask

  // Fields: {repeat count[7:0], valid, accept, ready}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {8'd18, 3'b100},  // R1 fill past one lap
    {8'd1,  3'b110},  // R11 step-back wraps below cell 0
    {8'd1,  3'b010},  // R8 overlaps the group just frozen
    {8'd6,  3'b100},
    {8'd1,  3'b010},
    {8'd10, 3'b101},  // R6 read while sampling
    {8'd4,  3'b110},  // R8 back-to-back accepts overlap
    {8'd4,  3'b101},  // R5 released cells reused
    {8'd3,  3'b100}, {8'd1, 3'b110},
    {8'd3,  3'b100}, {8'd1, 3'b110},
    {8'd3,  3'b100}, {8'd1, 3'b110},
    {8'd3,  3'b100}, {8'd1, 3'b110},
    {8'd3,  3'b100}, {8'd1, 3'b110},  // R7 queue full
    {8'd30, 3'b101}                  // drain
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL R10 watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin : main
    int firstData;
    modelReset();
    doReset();
    // Table-driven phase
    for (int n = 0; n < NV; n++) begin
      for (int k = 0; k < int'(VEC[n][10:3]); k++)
        step(VEC[n][2], VEC[n][1], VEC[n][0]);
    end

    // Directed: tile the whole ring with frozen groups
    doReset();
    firstData = dataCtr;
    for (int e = 0; e < Q; e++) begin
      repeat (G) step(1, 0, 0);
      step(0, 1, 0);
    end
    chk("R7 eventsPending full", eventsPending, Q);
    step(1, 0, 0);
    chk("R9 bufOverflow set", bufOverflow, 1);
    step(0, 1, 0);
    chk("R7 full-queue reject", trigRejectCnt, 1);
    step(0, 0, 1);
    chk("R2 first group addr", rdAddr, 0);
    chk("R3 first group soe", rdSoe, 1);
    chk("R1 first group data", rdData, firstData);
    repeat (Q * G - 1) step(0, 0, 1);
    step(1, 0, 1);
    chk("R3 idle read", rdValid, 0);
    chk("R9 overflow sticky", bufOverflow, 1);

    // Directed: reset clears freeze marks and pointer
    doReset();
    repeat (G) step(1, 0, 0);
    step(0, 1, 0);
    step(0, 0, 1);
    chk("R10 pointer restart addr", rdAddr, 0);
    chk("R10 overflow cleared", bufOverflow, 0);
    repeat (G - 1) step(0, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end
endmodule